// File: doc/BRIEF.md
# XAUI Receive Code-Group Translator

This block sits after an 8b/10b decoder on the receive side of a 10-gigabit attachment-unit path. It turns each decoded code group into the control flag and byte that the XGMII side expects. Every lane carries a 9-bit symbol, made of a K flag and a byte, together with a flag that marks a code group the decoder could not decode. One mode pin selects the translation. In XAUI mode, data bytes pass through with the control flag cleared. Known special characters become idle, sequence, start, terminate or error control bytes, and anything bad or unknown becomes the error byte. In gigabit Ethernet mode, symbols pass through untouched, and only invalid code groups are replaced by the error symbol.

Symbols enter and leave as a valid/ready stream, and all lanes share one beat. The output stage is a single register. A beat is taken when `in_valid && in_ready`. `in_ready` is high when the output register is empty, or when its content is being taken on the same edge (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its value and no new beat is taken. The mode pin is sampled with each accepted beat.

Symbol encoding: bit 8 is the K flag and bits 7:0 are the code-group byte. The special characters are K28.0 = 1C, K28.3 = 7C, K28.4 = 9C, K28.5 = BC, K27.7 = FB, K29.7 = FD and K30.7 = FE. Each output lane is a control flag plus a byte. `xaui_mode` = 1 selects XAUI translation and 0 selects gigabit pass-through.

Top module: `xaui_rx_xlat`

## Requirements
- R1: In XAUI mode, a valid symbol with K flag 0 gives control 0 and the same byte.
- R2: In XAUI mode, a valid K symbol with byte 1C, 7C or BC gives control 1 and byte 07 (idle).
- R3: In XAUI mode, a valid K symbol with byte 9C gives control 1 and byte 9C (sequence).
- R4: In XAUI mode, valid K symbols FB, FD and FE give control 1 with byte FB (start), FD (terminate) and FE (error).
- R5: In XAUI mode, a symbol whose invalid flag is set gives control 1 and byte FE, whatever its value.
- R6: In XAUI mode, a valid K symbol whose byte is none of 1C, 7C, 9C, BC, FB, FD, FE is reserved and gives control 1 and byte FE.
- R7: In gigabit mode, a valid symbol passes unchanged: control = bit 8, byte = bits 7:0.
- R8: In gigabit mode, a symbol whose invalid flag is set becomes control 1, byte FE (9-bit value 1FE).
- R9: An accepted beat appears on the outputs with `out_valid` high one clock later. A cycle with no beat offered while `out_ready` is high leaves `out_valid` low.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the outputs and `out_valid` stay stable.
- R11: A synchronous active-high reset clears `out_valid` and sets every output lane to control 1, byte 07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xaui_mode | input | 1 | 1 = XAUI translation, 0 = gigabit pass-through |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_sym | input | 9*LANES | Per lane: K flag (bit 8) and byte (bits 7:0) |
| in_bad | input | LANES | Per lane: invalid code-group flag |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_ctl | output | LANES | Per lane XGMII control flag |
| out_byte | output | 8*LANES | Per lane XGMII byte |

## Verification
The assertions check on every cycle that the handshake behaves: an accepted beat becomes valid output next cycle, a stalled output holds, and reset leaves idle. They also check, for every accepted beat, that invalid symbols map to the error byte in both modes and that XAUI data symbols keep their byte with control cleared. Only the bench's sweeps over all 256 byte values, with the K flag, the invalid flag and the mode each both ways, can show that every special and reserved character lands on the right control byte.

// File: rtl/xrx_pkg.sv
package xrx_pkg;
  localparam int SYM_W  = 9;
  localparam int BYTE_W = 8;

  localparam logic [7:0] KB_K28_0 = 8'h1C;
  localparam logic [7:0] KB_K28_3 = 8'h7C;
  localparam logic [7:0] KB_K28_4 = 8'h9C;
  localparam logic [7:0] KB_K28_5 = 8'hBC;
  localparam logic [7:0] KB_K27_7 = 8'hFB;
  localparam logic [7:0] KB_K29_7 = 8'hFD;
  localparam logic [7:0] KB_K30_7 = 8'hFE;

  localparam logic [7:0] XG_IDLE  = 8'h07;
  localparam logic [7:0] XG_SEQ   = 8'h9C;
  localparam logic [7:0] XG_START = 8'hFB;
  localparam logic [7:0] XG_TERM  = 8'hFD;
  localparam logic [7:0] XG_ERROR = 8'hFE;

  typedef enum logic [2:0] {
    KC_IDLE  = 3'd0,
    KC_SEQ   = 3'd1,
    KC_START = 3'd2,
    KC_TERM  = 3'd3,
    KC_ERR   = 3'd4,
    KC_RSVD  = 3'd5
  } kclass_e;

  typedef struct packed {
    logic       ctl;
    logic [7:0] dat;
  } xg_sym_t;

  localparam xg_sym_t XG_SYM_IDLE  = '{ctl: 1'b1, dat: XG_IDLE};
  localparam xg_sym_t XG_SYM_ERROR = '{ctl: 1'b1, dat: XG_ERROR};
endpackage

// File: rtl/xrx_kclass.sv
module xrx_kclass
  import xrx_pkg::*;
(
  input  logic [BYTE_W-1:0] kbyte,
  output kclass_e           cls
);
  always_comb begin
    unique case (kbyte)
      KB_K28_0, KB_K28_3, KB_K28_5: cls = KC_IDLE;
      KB_K28_4:                     cls = KC_SEQ;
      KB_K27_7:                     cls = KC_START;
      KB_K29_7:                     cls = KC_TERM;
      KB_K30_7:                     cls = KC_ERR;
      default:                      cls = KC_RSVD;
    endcase
  end
endmodule

// File: rtl/xrx_lane_map.sv
module xrx_lane_map
  import xrx_pkg::*;
(
  input  logic             xaui_mode,
  input  logic [SYM_W-1:0] sym,
  input  logic             bad,
  output xg_sym_t          res
);
  kclass_e cls;

  xrx_kclass u_kclass (
    .kbyte (sym[BYTE_W-1:0]),
    .cls   (cls)
  );

  always_comb begin
    if (bad) begin
      res = XG_SYM_ERROR;
    end else if (!xaui_mode) begin
      res.ctl = sym[SYM_W-1];
      res.dat = sym[BYTE_W-1:0];
    end else if (!sym[SYM_W-1]) begin
      res.ctl = 1'b0;
      res.dat = sym[BYTE_W-1:0];
    end else begin
      res.ctl = 1'b1;
      unique case (cls)
        KC_IDLE:  res.dat = XG_IDLE;
        KC_SEQ:   res.dat = XG_SEQ;
        KC_START: res.dat = XG_START;
        KC_TERM:  res.dat = XG_TERM;
        default:  res.dat = XG_ERROR;
      endcase
    end
  end
endmodule

// File: rtl/xrx_out_stage.sv
module xrx_out_stage
  import xrx_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES-1:0]        nxt_ctl,
  input  logic [LANES*BYTE_W-1:0] nxt_byte,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES-1:0]        out_ctl,
  output logic [LANES*BYTE_W-1:0] out_byte
);
  logic                    v_q;
  logic [LANES-1:0]        ctl_q;
  logic [LANES*BYTE_W-1:0] byte_q;
  logic                    rst_d;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      v_q    <= 1'b0;
      ctl_q  <= '1;
      byte_q <= {LANES{XG_IDLE}};
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) begin
        ctl_q  <= nxt_ctl;
        byte_q <= nxt_byte;
      end
    end
  end

  assign out_valid = v_q;
  assign out_ctl   = ctl_q;
  assign out_byte  = byte_q;

  // R11: the state left by a reset edge is idle on every lane
  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r11_reset_idle: assert (!v_q && (&ctl_q) && byte_q == {LANES{XG_IDLE}})
        else $error("R11 output not idle after reset");
    end
  end

  a_r9_beat_emerges: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid)
    else $error("R9 accepted beat not presented");

  a_r9_no_beat_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid && out_ready |=> !out_valid)
    else $error("R9 valid without a beat");

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ctl) && $stable(out_byte))
    else $error("R10 output changed while stalled");

  a_r10_no_take_when_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready)
    else $error("R10 ready while stalled");
endmodule

// File: rtl/xaui_rx_xlat.sv
module xaui_rx_xlat
  import xrx_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    xaui_mode,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*SYM_W-1:0]  in_sym,
  input  logic [LANES-1:0]        in_bad,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES-1:0]        out_ctl,
  output logic [LANES*BYTE_W-1:0] out_byte
);
  logic [LANES-1:0]        nxt_ctl;
  logic [LANES*BYTE_W-1:0] nxt_byte;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xg_sym_t          mapped;
    logic [SYM_W-1:0] lsym;

    assign lsym = in_sym[g*SYM_W +: SYM_W];

    xrx_lane_map u_map (
      .xaui_mode (xaui_mode),
      .sym       (lsym),
      .bad       (in_bad[g]),
      .res       (mapped)
    );

    assign nxt_ctl[g]                 = mapped.ctl;
    assign nxt_byte[g*BYTE_W +: BYTE_W] = mapped.dat;

    always_ff @(posedge clk) begin
      if (!rst && in_valid && in_ready) begin
        if (in_bad[g]) begin
          a_r5_r8_bad_is_error: assert (mapped.ctl && mapped.dat == XG_ERROR)
            else $error("R5/R8 invalid symbol not mapped to error");
        end
        if (xaui_mode && !in_bad[g] && !lsym[SYM_W-1]) begin
          a_r1_data_kept: assert (!mapped.ctl && mapped.dat == lsym[BYTE_W-1:0])
            else $error("R1 data byte altered");
        end
        if (!xaui_mode && !in_bad[g]) begin
          a_r7_gige_pass: assert ({mapped.ctl, mapped.dat} == lsym)
            else $error("R7 gigabit symbol altered");
        end
      end
    end
  end

  xrx_out_stage #(.LANES(LANES)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .nxt_ctl   (nxt_ctl),
    .nxt_byte  (nxt_byte),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ctl   (out_ctl),
    .out_byte  (out_byte)
  );
endmodule

// File: tb/tb_xaui_rx_xlat.sv
module tb_xaui_rx_xlat;
  logic       clk = 1'b0;
  logic       rst;
  logic       xaui_mode;
  logic       in_valid;
  logic       in_ready;
  logic [8:0] in_sym;
  logic [0:0] in_bad;
  logic       out_valid;
  logic       out_ready;
  logic [0:0] out_ctl;
  logic [7:0] out_byte;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xaui_rx_xlat #(.LANES(1)) dut (
    .clk(clk), .rst(rst), .xaui_mode(xaui_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym), .in_bad(in_bad),
    .out_valid(out_valid), .out_ready(out_ready), .out_ctl(out_ctl), .out_byte(out_byte)
  );

  function automatic logic [8:0] expect_of(input bit xm, input logic [8:0] s, input bit b);
    if (b) return 9'h1FE;
    if (!xm) return s;
    if (!s[8]) return {1'b0, s[7:0]};
    case (s[7:0])
      8'h1C, 8'h7C, 8'hBC: return 9'h107;
      8'h9C: return 9'h19C;
      8'hFB: return 9'h1FB;
      8'hFD: return 9'h1FD;
      default: return 9'h1FE;
    endcase
  endfunction

  function automatic string req_of(input bit xm, input logic [8:0] s, input bit b);
    if (!xm) return b ? "R8" : "R7";
    if (b) return "R5";
    if (!s[8]) return "R1";
    case (s[7:0])
      8'h1C, 8'h7C, 8'hBC: return "R2";
      8'h9C: return "R3";
      8'hFB, 8'hFD, 8'hFE: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; xaui_mode = 1'b1; in_valid = 1'b0; in_sym = '0; in_bad = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state is not valid, control 1, byte 07
    check("R11", {out_valid, out_ctl, out_byte}, {1'b0, 1'b1, 8'h07});
    rst = 1'b0;

    // Sweep of both modes, K flag, invalid flag and all bytes (R1..R9)
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < 2; k++) begin
          for (int v = 0; v < 256; v++) begin
            logic [8:0] s;
            logic [8:0] e;
            s = {k[0], v[7:0]};
            e = expect_of(m[0], s, b[0]);
            xaui_mode = m[0]; in_sym = s; in_bad = b[0]; in_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check(req_of(m[0], s, b[0]), {out_valid, out_ctl, out_byte}, {1'b1, e});
          end
        end
      end
    end

    // R9: no beat offered leaves out_valid low
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9", {9'd0, out_valid}, 10'd0);

    // R10: stall behaviour
    out_ready = 1'b0; xaui_mode = 1'b1; in_bad = 1'b0; in_sym = 9'h055; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9", {out_valid, out_ctl, out_byte}, {1'b1, 1'b0, 8'h55});
    in_sym = 9'h1FB;
    check("R10", {9'd0, in_ready}, 10'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", {out_valid, out_ctl, out_byte}, {1'b1, 1'b0, 8'h55});
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10", {out_valid, out_ctl, out_byte}, {1'b1, 1'b1, 8'hFB});
    in_valid = 1'b0;

    // R11: reset in mid-stream returns to idle
    in_valid = 1'b1; in_sym = 9'h0AA;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11", {out_valid, out_ctl, out_byte}, {1'b0, 1'b1, 8'h07});
    rst = 1'b0; in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    finish_run();
  end
endmodule